// File: doc/BRIEF.md
# Lane-Partitioned Packed Adder

This block adds two packed operand words. A two-bit width select, sampled together with the operands, decides how the word is split. It can act as a set of independent 8-bit, 16-bit or 32-bit adders working side by side, or as one adder across the whole word. No carry crosses from one element into the next, so every element wraps modulo its own width. This lets one adder serve as many parallel element additions as fit in the datapath.

The operands are captured on a rising clock edge when the valid strobe is high. The packed sum appears on the registered output one clock later, and the output valid follows the input valid with the same one-cycle delay. While the strobe is low, the result register keeps its last value. The datapath width is a parameter. At 32 bits, the 32-bit element code and the full-width code give the same single 32-bit addition.

Top module: `packed_lane_adder`

## Requirements
- R1: While rstN is low, sumOut is zero and validOut is low.
- R2: validOut equals the value validIn had at the previous rising clock edge.
- R3: widthSel = 2'b00 selects 8-bit elements. Each byte of sumOut is the sum of the matching operand bytes modulo 256.
- R4: widthSel = 2'b01 selects 16-bit elements. DATA_W/16 independent additions are made, each modulo 2^16.
- R5: widthSel = 2'b10 selects 32-bit elements. DATA_W/32 independent additions are made, each modulo 2^32.
- R6: widthSel = 2'b11 makes one addition across the full DATA_W bits, modulo 2^DATA_W.
- R7: The carry out of the top bit of an element is discarded and never changes the next element. For example, all-ones plus one in every element gives zero in every element.
- R8: When validIn is low at a rising edge, sumOut keeps its previous value.
- R9: Element i occupies bits [(i+1)*W-1 : i*W] of the operands and of sumOut, with element 0 in the least significant bits.
- R10: With DATA_W = 32, widthSel = 2'b10 and 2'b11 both give a single 32-bit addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operands and width select are valid this cycle |
| widthSel | input | 2 | Element width code (00 = 8, 01 = 16, 10 = 32, 11 = full) |
| opA | input | DATA_W | First packed operand |
| opB | input | DATA_W | Second packed operand |
| sumOut | output | DATA_W | Registered packed sum |
| validOut | output | 1 | validIn delayed by one clock |

## Verification
The bench targets element boundaries with all-ones plus one in every mode. If a carry leaked across a boundary, the upper element would become one instead of zero. A low byte of 0xFF plus one in 8-bit mode shows whether byte 1 stays clear, while the same operands in full mode must carry into it. Patterns with a distinct value per element would expose a swapped or shifted lane mapping. Idle cycles placed between valid ones would catch a result register that reloads without the strobe. A second instance at 32-bit width checks that the 32-bit code behaves as the full-width adder there.

// File: rtl/packed_lane_adder_pkg.sv
package packed_lane_adder_pkg;

  typedef enum logic [1:0] {
    WIDTH_8    = 2'b00,
    WIDTH_16   = 2'b01,
    WIDTH_32   = 2'b10,
    WIDTH_FULL = 2'b11
  } widthSel_e;

  typedef struct packed {
    logic capture;
  } dpStrobe_t;

endpackage

// File: rtl/lane_adder_ctrl.sv
module lane_adder_ctrl
  import packed_lane_adder_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NUM_BYTES = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 validIn,
  input  logic [1:0]           widthSel,
  output dpStrobe_t            strobes,
  output logic [NUM_BYTES-1:0] carryKill,
  output logic                 validOut
);

  // A set bit b blocks the carry coming into byte b from byte b-1.
  always_comb begin
    carryKill = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      unique case (widthSel)
        WIDTH_8:  carryKill[b] = 1'b1;
        WIDTH_16: carryKill[b] = (b % 2) == 0;
        WIDTH_32: carryKill[b] = (b % 4) == 0;
        default:  carryKill[b] = (b == 0);
      endcase
    end
  end

  assign strobes.capture = validIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (validOut == $past(validIn)));

  // R4
  half_word_cuts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (widthSel == WIDTH_16) |-> ($countones(carryKill) == NUM_BYTES / 2));

endmodule

// File: rtl/lane_adder_dp.sv
module lane_adder_dp
  import packed_lane_adder_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NUM_BYTES = DATA_W / 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobes,
  input  logic [NUM_BYTES-1:0] carryKill,
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  output logic [DATA_W-1:0]    sumOut
);

  logic [NUM_BYTES-1:0] carryIn;
  logic [DATA_W-1:0]    sumComb;

  assign carryIn[0] = 1'b0;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic cinGated;
    assign cinGated = carryIn[b] & ~carryKill[b];
    if (b < NUM_BYTES - 1) begin : g_mid
      assign {carryIn[b+1], sumComb[b*8 +: 8]} =
        {1'b0, opA[b*8 +: 8]} + {1'b0, opB[b*8 +: 8]} + {8'b0, cinGated};
    end else begin : g_top
      assign sumComb[b*8 +: 8] = opA[b*8 +: 8] + opB[b*8 +: 8] + {7'b0, cinGated};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sumOut <= '0;
    else if (strobes.capture) sumOut <= sumComb;
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(sumOut));

endmodule

// File: rtl/packed_lane_adder.sv
module packed_lane_adder
  import packed_lane_adder_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NUM_BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [1:0]        widthSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] sumOut,
  output logic              validOut
);

  dpStrobe_t            strobes;
  logic [NUM_BYTES-1:0] carryKill;

  lane_adder_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .widthSel (widthSel),
    .strobes  (strobes),
    .carryKill(carryKill),
    .validOut (validOut)
  );

  lane_adder_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .carryKill(carryKill),
    .opA      (opA),
    .opB      (opB),
    .sumOut   (sumOut)
  );

  // R3
  byte_lane0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && widthSel == WIDTH_8) |=>
      (sumOut[7:0] == $past(opA[7:0] + opB[7:0])));

  // R6
  full_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && widthSel == WIDTH_FULL) |=> (sumOut == $past(opA + opB)));

endmodule

// File: tb/packed_lane_adder_test.sv
`timescale 1ns/1ps
module packed_lane_adder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [1:0]  widthSel = 2'b00;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [63:0] sumOut;
  logic        validOut;
  logic [31:0] sumOut32;
  logic        validOut32;

  int compared = 0;
  int mismatched = 0;

  logic [63:0] expSum = '0;
  logic [31:0] expSum32 = '0;
  logic        expValid = 1'b0;
  string       curTag = "R1";
  string       curTag32 = "R1";

  always #2.5 clk = ~clk;

  packed_lane_adder #(.DATA_W(64)) uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .widthSel(widthSel),
    .opA(opA), .opB(opB), .sumOut(sumOut), .validOut(validOut)
  );

  packed_lane_adder #(.DATA_W(32)) uut32 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .widthSel(widthSel),
    .opA(opA[31:0]), .opB(opB[31:0]), .sumOut(sumOut32), .validOut(validOut32)
  );

  function automatic logic [63:0] refAdd(logic [63:0] a, logic [63:0] b,
                                         logic [1:0] code, int dw);
    int w;
    logic [63:0] m, r, ea, eb;
    w = (code == 2'b00) ? 8 : (code == 2'b01) ? 16 : (code == 2'b10) ? 32 : 64;
    if (w > dw) w = dw;
    m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    r = '0;
    for (int i = 0; i < dw / w; i++) begin
      ea = (a >> (i * w)) & m;
      eb = (b >> (i * w)) & m;
      r  = r | (((ea + eb) & m) << (i * w));
    end
    return r;
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check64(curTag, sumOut, expSum);
    check64(curTag32, {32'b0, sumOut32}, {32'b0, expSum32});
    check64("R2", {63'b0, validOut}, {63'b0, expValid});
    check64("R2", {63'b0, validOut32}, {63'b0, expValid});
  endtask

  task automatic step(bit v, logic [1:0] code, logic [63:0] a, logic [63:0] b,
                      string tag);
    @(negedge clk);
    compareAll();
    validIn  = v;
    widthSel = code;
    opA      = a;
    opB      = b;
    expValid = v;
    if (v) begin
      expSum   = refAdd(a, b, code, 64);
      expSum32 = refAdd(a, b, code, 32)[31:0];
      curTag   = tag;
      curTag32 = (code[1]) ? "R10" : tag;
    end else begin
      curTag   = "R8";
      curTag32 = "R8";
    end
  endtask

  initial begin
    #(5.0 * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: outputs while reset is held
    repeat (3) @(negedge clk);
    compareAll();
    rstN = 1'b1;

    // R7: all-ones plus one per element wraps to zero in each mode
    step(1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R7");
    step(1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, "R7");
    step(1, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, "R7");
    step(1, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, "R6");
    // R9: lane placement and isolation at byte 0
    step(1, 2'b00, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, "R9");
    step(1, 2'b11, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, "R6");
    step(1, 2'b00, 64'h0807_0605_0403_0201, 64'h1010_1010_1010_1010, "R9");
    step(1, 2'b01, 64'h8000_7FFF_8000_0001, 64'h8000_0001_0001_FFFF, "R4");
    step(1, 2'b10, 64'h8000_0000_FFFF_FFFE, 64'h8000_0000_0000_0003, "R5");
    step(1, 2'b00, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, "R3");
    // R8: idle cycles with changing operands keep the result
    step(0, 2'b11, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, "R8");
    step(0, 2'b00, 64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F, "R8");
    // R10: 32-bit code at the narrow instance is full width
    step(1, 2'b10, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, "R5");

    for (int n = 0; n < 400; n++) begin
      logic [1:0]  c;
      logic [63:0] a, b;
      string       t;
      c = 2'($urandom_range(0, 3));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      t = (c == 2'b00) ? "R3" : (c == 2'b01) ? "R4" : (c == 2'b10) ? "R5" : "R6";
      step(($urandom_range(0, 4) != 0), c, a, b, t);
    end
    step(0, 2'b00, '0, '0, "R8");
    @(negedge clk);
    compareAll();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule